// File: doc/BRIEF.md
# Accumulator Machine Register Bank

This block holds the architectural registers of a 16-bit accumulator machine. It has thirty-two general registers and four special ones: the accumulator, a memory pointer, a stack pointer and the program counter. A single 6-bit index space addresses all of them. Indices 0 to 31 are the general registers. Indices 60 to 63 are the specials. Indices 32 to 59 are holes.

Each cycle the surrounding core presents at most one register operation. The operation can be one of:

- a sign-extended immediate load;
- an upper-byte immediate load;
- a register-to-register move, including a link capture of the program counter;
- an increment or a decrement;
- a write of memory data, either for a word load or for a pop.

Each class may only name the registers its range allows. A request outside that range is refused, nothing is written, and an error flag is raised.

Two independent read ports return register contents one cycle after the index is presented. The four specials are also visible on their own output ports at all times. A dedicated program-counter update port lets fetch logic move the PC without using the operation path.

Top module: `accum_regbank`

## Requirements
- R1: While `rst` is high at a clock edge, every register is cleared to zero, both read outputs go to zero and `err` goes to zero.
- R2: Read ports are registered. `ra_data`/`rb_data` show, one cycle later, the value the named index held before that edge. Indices 0–31 are general registers, 60 is `acc`, 61 `mptr`, 62 `sp`, 63 `pc`, and indices 32–59 read as zero.
- R3: `op`=1 (load immediate) writes `imm` sign-extended to 16 bits into any implemented index (0–31, 60–63).
- R4: `op`=2 (upper immediate) writes `imm` into bits 15:8 of any implemented index and leaves bits 7:0 unchanged.
- R5: `op`=3 (move) copies index `src_idx` into `dst_idx`; both must be implemented. When `src_idx` is 63, the value stored is PC+4 modulo 2^16.
- R6: `op`=4 adds one and `op`=5 subtracts one from `dst_idx`, wrapping modulo 2^16, in a single write. These are only legal for indices 0–31.
- R7: `op`=6 (word load) writes `mem_data` into `dst_idx` and is legal only for indices 0–15. `op`=7 (pop) writes `mem_data` and is legal only for indices 0–31.
- R8: An operation whose destination, or move source, is outside its legal range writes nothing and sets `err` high on the following cycle. A legal operation, or `op`=0 (no operation), leaves `err` low on the following cycle.
- R9: When `pc_we` is high, `pc` takes `pc_wdata` at that edge. This overrides any operation that targets index 63 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation code (0 none, 1 load imm, 2 upper imm, 3 move, 4 inc, 5 dec, 6 word load, 7 pop) |
| dst_idx | input | 6 | Destination register index |
| src_idx | input | 6 | Source register index for a move |
| imm | input | 8 | Immediate operand |
| mem_data | input | 16 | Data for word-load and pop writes |
| pc_we | input | 1 | Program-counter update strobe |
| pc_wdata | input | 16 | Program-counter update value |
| ra_idx | input | 6 | Read port A index |
| rb_idx | input | 6 | Read port B index |
| ra_data | output | 16 | Read port A data, one cycle latency |
| rb_data | output | 16 | Read port B data, one cycle latency |
| acc | output | 16 | Accumulator |
| mptr | output | 16 | Memory pointer |
| sp | output | 16 | Stack pointer |
| pc | output | 16 | Program counter |
| err | output | 1 | Illegal-access flag for the previous cycle's operation |

## Verification
The embedded properties assume that every input is driven to a known value at each clock edge, and that `op` is always one of the eight defined codes. The bench keeps within this by driving every input from its own tasks on the falling edge, with no undriven bits. Random indices are drawn from a mix that reaches low general registers, high general registers, the specials and the unimplemented holes. The program-counter port is strobed on about one cycle in eight, so that it collides with operations on index 63 often.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_LDI   = 3'd1,
    OP_LDUI  = 3'd2,
    OP_MOV   = 3'd3,
    OP_INC   = 3'd4,
    OP_DEC   = 3'd5,
    OP_LDMEM = 3'd6,
    OP_POPW  = 3'd7
  } op_e;

endpackage

// File: rtl/regbank_gpr.sv
module regbank_gpr #(
  parameter int W   = 16,
  parameter int N   = 32,
  parameter int NRD = 4,
  parameter int AW  = $clog2(N)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][W-1:0]   rdata
);

  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end

endmodule

// File: rtl/regbank_special.sv
module regbank_special #(
  parameter int W      = 16,
  parameter int N_SPEC = 4,
  parameter int SEL_W  = $clog2(N_SPEC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [W-1:0]              wr_data,
  input  logic                      pc_we,
  input  logic [W-1:0]              pc_wdata,
  output logic [N_SPEC-1:0][W-1:0]  spec_q
);

  localparam int PC_SLOT = N_SPEC - 1;

  for (genvar s = 0; s < N_SPEC; s++) begin : g_spec
    if (s == PC_SLOT) begin : g_pc
      // dedicated update port wins over the operation path
      always_ff @(posedge clk) begin
        if (rst)                                  spec_q[s] <= '0;
        else if (pc_we)                           spec_q[s] <= pc_wdata;
        else if (wr_en && wr_sel == SEL_W'(s))    spec_q[s] <= wr_data;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)                                  spec_q[s] <= '0;
        else if (wr_en && wr_sel == SEL_W'(s))    spec_q[s] <= wr_data;
      end
    end
  end

  AST_PC_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    pc_we |=> spec_q[PC_SLOT] == $past(pc_wdata)); // R9

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> spec_q == '0); // R1

endmodule

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int W         = 16,
  parameter int IDX_W     = 6,
  parameter int IMM_W     = 8,
  parameter int N_GPR     = 32,
  parameter int N_LS      = 16,
  parameter int SPEC_BASE = 60,
  parameter int LINK_OFS  = 4
) (
  input  op_e               op,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [IMM_W-1:0]  imm,
  input  logic [W-1:0]      mem_data,
  input  logic [W-1:0]      dst_val,
  input  logic [W-1:0]      src_val,
  input  logic [W-1:0]      pc_val,
  output logic              wr_en,
  output logic [W-1:0]      wr_data,
  output logic              illegal
);

  localparam logic [IDX_W-1:0] GPR_LIM = IDX_W'(N_GPR);
  localparam logic [IDX_W-1:0] LS_LIM  = IDX_W'(N_LS);
  localparam logic [IDX_W-1:0] SBASE   = IDX_W'(SPEC_BASE);
  localparam logic [IDX_W-1:0] PC_IDX  = IDX_W'(SPEC_BASE + 3);

  logic any_dst, any_src, gp_dst, ls_dst;

  assign any_dst = (dst_idx < GPR_LIM) || (dst_idx >= SBASE);
  assign any_src = (src_idx < GPR_LIM) || (src_idx >= SBASE);
  assign gp_dst  = dst_idx < GPR_LIM;
  assign ls_dst  = dst_idx < LS_LIM;

  always_comb begin
    wr_en   = 1'b0;
    wr_data = dst_val;
    illegal = 1'b0;
    unique case (op)
      OP_NOP: ;
      OP_LDI: begin
        illegal = !any_dst;
        wr_en   = any_dst;
        wr_data = {{(W-IMM_W){imm[IMM_W-1]}}, imm};
      end
      OP_LDUI: begin
        illegal = !any_dst;
        wr_en   = any_dst;
        wr_data = {imm, dst_val[W-IMM_W-1:0]};
      end
      OP_MOV: begin
        illegal = !(any_dst && any_src);
        wr_en   = any_dst && any_src;
        wr_data = (src_idx == PC_IDX) ? pc_val + W'(LINK_OFS) : src_val;
      end
      OP_INC: begin
        illegal = !gp_dst;
        wr_en   = gp_dst;
        wr_data = dst_val + W'(1);
      end
      OP_DEC: begin
        illegal = !gp_dst;
        wr_en   = gp_dst;
        wr_data = dst_val - W'(1);
      end
      OP_LDMEM: begin
        illegal = !ls_dst;
        wr_en   = ls_dst;
        wr_data = mem_data;
      end
      OP_POPW: begin
        illegal = !gp_dst;
        wr_en   = gp_dst;
        wr_data = mem_data;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/accum_regbank.sv
module accum_regbank
  import regbank_pkg::*;
#(
  parameter int W         = 16,
  parameter int IDX_W     = 6,
  parameter int IMM_W     = 8,
  parameter int N_GPR     = 32,
  parameter int N_LS      = 16,
  parameter int SPEC_BASE = 60,
  parameter int LINK_OFS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [IMM_W-1:0]  imm,
  input  logic [W-1:0]      mem_data,
  input  logic              pc_we,
  input  logic [W-1:0]      pc_wdata,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [W-1:0]      ra_data,
  output logic [W-1:0]      rb_data,
  output logic [W-1:0]      acc,
  output logic [W-1:0]      mptr,
  output logic [W-1:0]      sp,
  output logic [W-1:0]      pc,
  output logic              err
);

  localparam int N_SPEC = 4;
  localparam int SEL_W  = $clog2(N_SPEC);
  localparam int GPR_AW = $clog2(N_GPR);
  localparam int NRD    = 4;  // A, B, destination, move source
  localparam logic [IDX_W-1:0] GPR_LIM = IDX_W'(N_GPR);
  localparam logic [IDX_W-1:0] SBASE   = IDX_W'(SPEC_BASE);

  op_e op_q;
  assign op_q = op_e'(op);

  logic [NRD-1:0][IDX_W-1:0]  rd_idx;
  logic [NRD-1:0][GPR_AW-1:0] gpr_addr;
  logic [NRD-1:0][W-1:0]      gpr_rd;
  logic [NRD-1:0][W-1:0]      rd_val;
  logic [N_SPEC-1:0][W-1:0]   spec_q;

  logic           wr_en, illegal;
  logic [W-1:0]   wr_data;
  logic           gpr_we, spec_we;
  logic [SEL_W-1:0] spec_sel;

  assign rd_idx = {src_idx, dst_idx, rb_idx, ra_idx};

  for (genvar p = 0; p < NRD; p++) begin : g_port
    assign gpr_addr[p] = rd_idx[p][GPR_AW-1:0];
    always_comb begin
      if (rd_idx[p] < GPR_LIM)     rd_val[p] = gpr_rd[p];
      else if (rd_idx[p] >= SBASE) rd_val[p] = spec_q[SEL_W'(rd_idx[p] - SBASE)];
      else                         rd_val[p] = '0;
    end
  end

  regbank_gpr #(.W(W), .N(N_GPR), .NRD(NRD), .AW(GPR_AW)) u_gpr (
    .clk   (clk),
    .rst   (rst),
    .we    (gpr_we),
    .waddr (dst_idx[GPR_AW-1:0]),
    .wdata (wr_data),
    .raddr (gpr_addr),
    .rdata (gpr_rd)
  );

  regbank_decode #(
    .W(W), .IDX_W(IDX_W), .IMM_W(IMM_W), .N_GPR(N_GPR),
    .N_LS(N_LS), .SPEC_BASE(SPEC_BASE), .LINK_OFS(LINK_OFS)
  ) u_dec (
    .op       (op_q),
    .dst_idx  (dst_idx),
    .src_idx  (src_idx),
    .imm      (imm),
    .mem_data (mem_data),
    .dst_val  (rd_val[2]),
    .src_val  (rd_val[3]),
    .pc_val   (spec_q[N_SPEC-1]),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .illegal  (illegal)
  );

  assign gpr_we   = wr_en && (dst_idx < GPR_LIM);
  assign spec_we  = wr_en && (dst_idx >= SBASE);
  assign spec_sel = SEL_W'(dst_idx - SBASE);

  regbank_special #(.W(W), .N_SPEC(N_SPEC), .SEL_W(SEL_W)) u_spec (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (spec_we),
    .wr_sel   (spec_sel),
    .wr_data  (wr_data),
    .pc_we    (pc_we),
    .pc_wdata (pc_wdata),
    .spec_q   (spec_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_data <= '0;
      rb_data <= '0;
      err     <= 1'b0;
    end else begin
      ra_data <= rd_val[0];
      rb_data <= rd_val[1];
      err     <= illegal;
    end
  end

  assign acc  = spec_q[0];
  assign mptr = spec_q[1];
  assign sp   = spec_q[2];
  assign pc   = spec_q[3];

  AST_UNIMPL_READ: assert property (@(posedge clk) disable iff (rst)
    (ra_idx >= GPR_LIM && ra_idx < SBASE) |=> ra_data == '0); // R2

  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (illegal && !pc_we) |=> $stable(spec_q)); // R8

  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
    illegal |=> err); // R8

  AST_LDUI_LOW: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_LDUI && dst_idx == SBASE) |=>
      acc[W-IMM_W-1:0] == $past(acc[W-IMM_W-1:0])); // R4

endmodule

// File: tb/tb_accum_regbank.sv
`timescale 1ns/1ps
module tb_accum_regbank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op = '0;
  logic [5:0]  dst_idx = '0, src_idx = '0, ra_idx = '0, rb_idx = '0;
  logic [7:0]  imm = '0;
  logic [15:0] mem_data = '0, pc_wdata = '0;
  logic        pc_we = 1'b0;
  logic [15:0] ra_data, rb_data, acc, mptr, sp, pc;
  logic        err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  accum_regbank dut (
    .clk(clk), .rst(rst), .op(op), .dst_idx(dst_idx), .src_idx(src_idx),
    .imm(imm), .mem_data(mem_data), .pc_we(pc_we), .pc_wdata(pc_wdata),
    .ra_idx(ra_idx), .rb_idx(rb_idx), .ra_data(ra_data), .rb_data(rb_data),
    .acc(acc), .mptr(mptr), .sp(sp), .pc(pc), .err(err)
  );

  // behavioural reference model
  logic [15:0] m [64];
  logic [15:0] m_ra = 0, m_rb = 0;
  logic        m_err = 0;

  function automatic bit impl(int i);
    return (i < 32) || (i >= 60);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m[i]) m[i] = 16'h0;
      m_ra = 0; m_rb = 0; m_err = 0;
    end else begin
      bit ok; bit wr; logic [15:0] v; int d; int s;
      d = dst_idx; s = src_idx;
      m_ra = m[ra_idx];
      m_rb = m[rb_idx];
      ok = 1; wr = 0; v = 0;
      case (op)
        3'd1: begin ok = impl(d); v = {{8{imm[7]}}, imm}; wr = ok; end
        3'd2: begin ok = impl(d); v = m[d]; v[15:8] = imm; wr = ok; end
        3'd3: begin ok = impl(d) && impl(s);
                    v = (s == 63) ? m[63] + 16'd4 : m[s]; wr = ok; end
        3'd4: begin ok = d < 32; v = m[d] + 16'd1; wr = ok; end
        3'd5: begin ok = d < 32; v = m[d] - 16'd1; wr = ok; end
        3'd6: begin ok = d < 16; v = mem_data; wr = ok; end
        3'd7: begin ok = d < 32; v = mem_data; wr = ok; end
        default: ;
      endcase
      if (wr && !(d == 63 && pc_we)) m[d] = v;
      if (pc_we) m[63] = pc_wdata;
      m_err = !ok;
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    check("R2 read port A", ra_data, m_ra);
    check("R2 read port B", rb_data, m_rb);
    check("R2 acc", acc, m[60]);
    check("R2 mptr", mptr, m[61]);
    check("R2 sp", sp, m[62]);
    check("R9 pc", pc, m[63]);
    check("R8 err", {15'h0, err}, {15'h0, m_err});
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_model();
  endtask

  task automatic do_op(logic [2:0] o, logic [5:0] d, logic [5:0] s,
                       logic [7:0] i, logic [15:0] md);
    op = o; dst_idx = d; src_idx = s; imm = i; mem_data = md;
    step();
    op = 3'd0;
  endtask

  task automatic rd(logic [5:0] idx, logic [15:0] exp, string tag);
    ra_idx = idx;
    step();
    check(tag, ra_data, exp);
  endtask

  function automatic logic [5:0] pick_idx();
    int r = $urandom % 8;
    case (r)
      0, 1, 2, 3: return 6'($urandom % 16);
      4:          return 6'(16 + $urandom % 16);
      5:          return 6'(60 + $urandom % 4);
      6:          return 6'(32 + $urandom % 28);
      default:    return 6'($urandom % 64);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) step();
    check("R1 acc after reset", acc, 16'h0);
    check("R1 pc after reset", pc, 16'h0);
    check("R1 err after reset", {15'h0, err}, 16'h0);
    rst = 1'b0;
    rd(6'd5, 16'h0, "R1 r5 after reset");
    rd(6'd62, 16'h0, "R1 sp after reset");

    do_op(3'd1, 6'd5, 6'd0, 8'h80, 16'h0);
    rd(6'd5, 16'hFF80, "R3 sign-extended load");
    do_op(3'd1, 6'd60, 6'd0, 8'h7F, 16'h0);
    check("R3 positive load to acc", acc, 16'h007F);

    do_op(3'd2, 6'd5, 6'd0, 8'h12, 16'h0);
    rd(6'd5, 16'h1280, "R4 upper byte load keeps low byte");

    pc_we = 1'b1; pc_wdata = 16'hFFFE;
    step();
    pc_we = 1'b0;
    do_op(3'd3, 6'd6, 6'd63, 8'h0, 16'h0);
    rd(6'd6, 16'h0002, "R5 link capture wraps PC+4");
    do_op(3'd3, 6'd61, 6'd5, 8'h0, 16'h0);
    check("R5 move into mptr", mptr, 16'h1280);

    do_op(3'd1, 6'd7, 6'd0, 8'hFF, 16'h0);
    do_op(3'd4, 6'd7, 6'd0, 8'h0, 16'h0);
    rd(6'd7, 16'h0000, "R6 increment wraps");
    do_op(3'd5, 6'd7, 6'd0, 8'h0, 16'h0);
    rd(6'd7, 16'hFFFF, "R6 decrement wraps");
    do_op(3'd4, 6'd60, 6'd0, 8'h0, 16'h0);
    check("R6 increment of acc refused", {15'h0, err}, 16'h1);
    check("R6 acc unchanged", acc, 16'h007F);

    do_op(3'd6, 6'd15, 6'd0, 8'h0, 16'hABCD);
    rd(6'd15, 16'hABCD, "R7 word load to r15");
    do_op(3'd6, 6'd16, 6'd0, 8'h0, 16'h1234);
    check("R7 word load to r16 refused", {15'h0, err}, 16'h1);
    rd(6'd16, 16'h0000, "R7 r16 untouched");
    do_op(3'd7, 6'd31, 6'd0, 8'h0, 16'h5555);
    rd(6'd31, 16'h5555, "R7 pop to r31");

    do_op(3'd1, 6'd40, 6'd0, 8'h33, 16'h0);
    check("R8 write to hole flagged", {15'h0, err}, 16'h1);
    rd(6'd40, 16'h0000, "R2 hole reads zero");
    do_op(3'd3, 6'd5, 6'd45, 8'h0, 16'h0);
    check("R8 move from hole flagged", {15'h0, err}, 16'h1);
    rd(6'd5, 16'h1280, "R8 destination untouched");
    check("R8 err clears after legal cycle", {15'h0, err}, 16'h0);

    pc_we = 1'b1; pc_wdata = 16'h0100;
    do_op(3'd1, 6'd63, 6'd0, 8'h22, 16'h0);
    pc_we = 1'b0;
    check("R9 update port wins", pc, 16'h0100);
    do_op(3'd1, 6'd63, 6'd0, 8'h22, 16'h0);
    check("R9 op path writes pc alone", pc, 16'h0022);

    for (int n = 0; n < 4000; n++) begin
      op       = 3'($urandom % 8);
      dst_idx  = pick_idx();
      src_idx  = pick_idx();
      ra_idx   = pick_idx();
      rb_idx   = pick_idx();
      imm      = 8'($urandom);
      mem_data = 16'($urandom);
      pc_we    = ($urandom % 8) == 0;
      pc_wdata = 16'($urandom);
      rst      = (n == 2000) || (n == 2001);
      step();
      if (n == 2001) check("R1 pc after mid-run reset", pc, 16'h0);
    end
    op = 3'd0; pc_we = 1'b0; rst = 1'b0;
    step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule